// File: doc/BRIEF.md
# Scale Update Power Ramp Sequencer

This block decides when a new gain scale and filter mode take effect on one output channel. A rising edge on one of several sync lines, picked by a select field, starts a sequence. A programmable hold-off count is waited out first. The block can then fade the channel's power envelope down to a floor and rest there for a programmable time. It then raises a one-clock commit strobe, at which the downstream datapath loads its pending scale and mode, and fades the envelope back up.

The envelope is a multiplier taken from a small writable table of ascending 14-bit levels. The fade up reads the table forwards and the fade down reads it backwards. Each direction has its own length. An optional interpolation mode stretches every table step over two samples. When ramping is disabled, the commit follows the hold-off directly and the envelope stays at full scale.

Top module: `scale_ramp_seq`

## Requirements
- R1: After reset and whenever no sequence runs, `env_out` equals full scale (16383, all ones) and `commit` is 0.
- R2: A sequence starts on the clock edge at which `sync_in[sync_sel]` is seen high after being low on the previous edge. Edges on the other sync lines have no effect.
- R3: The hold-off phase follows the start edge directly and lasts `holdoff`+1 cycles, with `env_out` at full scale.
- R4: With `ramp_en`=0, the hold-off is followed by exactly one commit cycle with `env_out` at full scale, and then by idle.
- R5: With `ramp_en`=1, the order after hold-off is fade down, rest, commit cycle, fade up, idle.
- R6: The fade down presents table entries `down_len_m1`, `down_len_m1`-1, ..., 0, which is `down_len_m1`+1 steps.
- R7: The fade up presents table entries 0, 1, ..., `up_len_m1`, which is `up_len_m1`+1 steps.
- R8: During the rest phase, which lasts `rest_len`+1 cycles, and during the commit cycle of a ramped sequence, `env_out` is 0.
- R9: With `interp_en`=1, each step takes two cycles. The first cycle shows the entry. The second shows floor((entry + next entry in travel order)/2), or the entry again on the final step of a fade.
- R10: `commit` is high for exactly one clock per sequence.
- R11: A sync edge that arrives while a sequence is running is ignored and does not change the sequence.
- R12: When `tab_wr_en` is high at a clock edge, `tab_wr_data` is stored at table address `tab_wr_addr`, and later fades use the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 4 | Candidate sync lines |
| sync_sel | input | 2 | Index of the sync line that starts a sequence |
| holdoff | input | 16 | Hold-off count (phase lasts value+1 cycles) |
| ramp_en | input | 1 | Enable fade down/up around the commit |
| interp_en | input | 1 | Enable two-sample interpolated steps |
| down_len_m1 | input | 6 | Fade-down step count minus one |
| up_len_m1 | input | 6 | Fade-up step count minus one |
| rest_len | input | 5 | Rest time at floor (lasts value+1 cycles) |
| tab_wr_en | input | 1 | Table write strobe |
| tab_wr_addr | input | 6 | Table write address |
| tab_wr_data | input | 14 | Table write level |
| env_out | output | 14 | Envelope multiplier |
| commit | output | 1 | One-clock strobe that applies pending scale and mode |

## Verification
The bench targets off-by-one cases in the hold-off and rest counters at zero and larger values. A wrong count shifts the commit strobe and every later envelope sample by a cycle. It drives both fade directions at length one and at the full 64 steps, with and without interpolation. A design that read the table forwards when fading down, or averaged past the end of a fade, would show wrong levels at the ends. Sync pulses are injected mid-sequence and on unselected lines. A design that restarted on them would repeat the hold-off and emit a second commit.

// File: rtl/srs_pkg.sv
package srs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HOLD = 3'd1,
      ST_DOWN = 3'd2,
      ST_REST = 3'd3,
      ST_UPD  = 3'd4,
      ST_UP   = 3'd5
   } srs_state_e;
endpackage

// File: rtl/srs_sync_pick.sv
module srs_sync_pick #(
   parameter int N_SYNC = 4,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SYNC-1:0] sync_in,
   input  logic [SEL_W-1:0]  sync_sel,
   output logic              sync_evt
);
   logic chosen;
   logic chosen_q;

   if (N_SYNC != (1 << SEL_W)) begin : g_bad_sel
      $error("srs_sync_pick: N_SYNC must equal 2**SEL_W");
   end

   assign chosen = sync_in[sync_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) chosen_q <= 1'b0;
      else        chosen_q <= chosen;
   end

   assign sync_evt = chosen & ~chosen_q;

   // R2: an event needs the selected line to have been low one edge earlier
   p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_evt |=> !sync_evt);
endmodule

// File: rtl/srs_ramp_table.sv
module srs_ramp_table #(
   parameter int ENV_W  = 14,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ENV_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [ENV_W-1:0]  rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [ENV_W-1:0]  rd_data_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [ENV_W-1:0] mem [DEPTH];

   if (DEPTH > 1024) begin : g_bad_depth
      $error("srs_ramp_table: table too deep");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data_a = mem[rd_addr_a];
   assign rd_data_b = mem[rd_addr_b];

   // R12: a write lands on the addressed entry
   p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/srs_seq_fsm.sv
module srs_seq_fsm
   import srs_pkg::*;
#(
   parameter int HOLD_W      = 16,
   parameter int LEN_W       = 6,
   parameter int REST_W      = 5,
   parameter bit INTERP_SUPP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_evt,
   input  logic [HOLD_W-1:0] holdoff,
   input  logic              ramp_en,
   input  logic              interp_en,
   input  logic [LEN_W-1:0]  down_len_m1,
   input  logic [LEN_W-1:0]  up_len_m1,
   input  logic [REST_W-1:0] rest_len,
   output srs_state_e        state,
   output logic [LEN_W-1:0]  step_idx,
   output logic              phase,
   output logic              interp_on,
   output logic              commit
);
   localparam int CNT_W = HOLD_W;

   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] len_m1;
   logic             step_last;
   logic             step_done;

   if (REST_W > HOLD_W) begin : g_bad_rest
      $error("srs_seq_fsm: REST_W must not exceed HOLD_W");
   end

   if (INTERP_SUPP) begin : g_interp
      assign interp_on = interp_en;
   end else begin : g_no_interp
      assign interp_on = 1'b0;
   end

   assign len_m1    = (state == ST_DOWN) ? down_len_m1 : up_len_m1;
   assign step_last = (step_idx == len_m1);
   assign step_done = !(interp_on && !phase);
   assign commit    = (state == ST_UPD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         step_idx <= '0;
         phase    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (sync_evt) begin
                  state <= ST_HOLD;
                  cnt   <= holdoff;
               end
            end
            ST_HOLD: begin
               if (cnt == '0) begin
                  step_idx <= '0;
                  phase    <= 1'b0;
                  state    <= ramp_en ? ST_DOWN : ST_UPD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_DOWN, ST_UP: begin
               if (!step_done) begin
                  phase <= 1'b1;
               end else begin
                  phase <= 1'b0;
                  if (step_last) begin
                     step_idx <= '0;
                     if (state == ST_DOWN) begin
                        state <= ST_REST;
                        cnt   <= CNT_W'(rest_len);
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     step_idx <= step_idx + 1'b1;
                  end
               end
            end
            ST_REST: begin
               if (cnt == '0) state <= ST_UPD;
               else           cnt   <= cnt - 1'b1;
            end
            ST_UPD: begin
               step_idx <= '0;
               phase    <= 1'b0;
               state    <= ramp_en ? ST_UP : ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: the commit strobe never lasts two clocks
   p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   // R5: the commit cycle is reached only from hold-off or rest
   p_update_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_UPD) |-> ($past(state) == ST_HOLD || $past(state) == ST_REST));

   // R3: hold-off counts down one per clock
   p_hold_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && cnt != '0) |=> (state == ST_HOLD && cnt == $past(cnt) - 1'b1));

   // R11: a sync during a running sequence does not restart it
   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_evt && state != ST_IDLE && state != ST_HOLD) |=> (state != ST_HOLD));
endmodule

// File: rtl/srs_env_gen.sv
module srs_env_gen
   import srs_pkg::*;
#(
   parameter int ENV_W = 14,
   parameter int LEN_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  srs_state_e        state,
   input  logic [LEN_W-1:0]  step_idx,
   input  logic              phase,
   input  logic              interp_on,
   input  logic              ramp_en,
   input  logic [LEN_W-1:0]  down_len_m1,
   input  logic [LEN_W-1:0]  up_len_m1,
   output logic [LEN_W-1:0]  addr_cur,
   output logic [LEN_W-1:0]  addr_nxt,
   input  logic [ENV_W-1:0]  lvl_cur,
   input  logic [ENV_W-1:0]  lvl_nxt,
   output logic [ENV_W-1:0]  env_out
);
   localparam logic [ENV_W-1:0] FULL = '1;

   logic             is_down;
   logic             last_step;
   logic [ENV_W:0]   pair_sum;
   logic [ENV_W-1:0] mid_lvl;

   assign is_down   = (state == ST_DOWN);
   assign addr_cur  = is_down ? (down_len_m1 - step_idx) : step_idx;
   assign addr_nxt  = is_down ? (addr_cur - 1'b1) : (addr_cur + 1'b1);
   assign last_step = is_down ? (step_idx == down_len_m1) : (step_idx == up_len_m1);
   assign pair_sum  = {1'b0, lvl_cur} + {1'b0, lvl_nxt};
   assign mid_lvl   = pair_sum[ENV_W:1];

   always_comb begin
      case (state)
         ST_DOWN, ST_UP: begin
            if (interp_on && phase && !last_step) env_out = mid_lvl;
            else                                  env_out = lvl_cur;
         end
         ST_REST: env_out = '0;
         ST_UPD:  env_out = ramp_en ? '0 : FULL;
         default: env_out = FULL;
      endcase
   end

   // R8: the floor is held through the rest phase
   p_rest_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REST) |-> (env_out == '0));

   // R1: idle output is full scale
   p_idle_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (env_out == FULL));
endmodule

// File: rtl/scale_ramp_seq.sv
module scale_ramp_seq
   import srs_pkg::*;
#(
   parameter int N_SYNC      = 4,
   parameter int SEL_W       = 2,
   parameter int HOLD_W      = 16,
   parameter int LEN_W       = 6,
   parameter int REST_W      = 5,
   parameter int ENV_W       = 14,
   parameter bit INTERP_SUPP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SYNC-1:0] sync_in,
   input  logic [SEL_W-1:0]  sync_sel,
   input  logic [HOLD_W-1:0] holdoff,
   input  logic              ramp_en,
   input  logic              interp_en,
   input  logic [LEN_W-1:0]  down_len_m1,
   input  logic [LEN_W-1:0]  up_len_m1,
   input  logic [REST_W-1:0] rest_len,
   input  logic              tab_wr_en,
   input  logic [LEN_W-1:0]  tab_wr_addr,
   input  logic [ENV_W-1:0]  tab_wr_data,
   output logic [ENV_W-1:0]  env_out,
   output logic              commit
);
   srs_state_e       state;
   logic             sync_evt;
   logic [LEN_W-1:0] step_idx;
   logic             phase;
   logic             interp_on;
   logic [LEN_W-1:0] addr_cur;
   logic [LEN_W-1:0] addr_nxt;
   logic [ENV_W-1:0] lvl_cur;
   logic [ENV_W-1:0] lvl_nxt;

   if (ENV_W < 2 || LEN_W < 1 || HOLD_W < 1) begin : g_bad_width
      $error("scale_ramp_seq: width parameter out of range");
   end

   srs_sync_pick #(.N_SYNC(N_SYNC), .SEL_W(SEL_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_sel(sync_sel),
      .sync_evt(sync_evt)
   );

   srs_seq_fsm #(.HOLD_W(HOLD_W), .LEN_W(LEN_W), .REST_W(REST_W),
                 .INTERP_SUPP(INTERP_SUPP)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .holdoff(holdoff),
      .ramp_en(ramp_en), .interp_en(interp_en), .down_len_m1(down_len_m1),
      .up_len_m1(up_len_m1), .rest_len(rest_len), .state(state),
      .step_idx(step_idx), .phase(phase), .interp_on(interp_on),
      .commit(commit)
   );

   srs_ramp_table #(.ENV_W(ENV_W), .ADDR_W(LEN_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .wr_en(tab_wr_en), .wr_addr(tab_wr_addr),
      .wr_data(tab_wr_data), .rd_addr_a(addr_cur), .rd_data_a(lvl_cur),
      .rd_addr_b(addr_nxt), .rd_data_b(lvl_nxt)
   );

   srs_env_gen #(.ENV_W(ENV_W), .LEN_W(LEN_W)) u_env (
      .clk(clk), .rst_n(rst_n), .state(state), .step_idx(step_idx),
      .phase(phase), .interp_on(interp_on), .ramp_en(ramp_en),
      .down_len_m1(down_len_m1), .up_len_m1(up_len_m1),
      .addr_cur(addr_cur), .addr_nxt(addr_nxt), .lvl_cur(lvl_cur),
      .lvl_nxt(lvl_nxt), .env_out(env_out)
   );

   // R4: an unramped commit leaves the envelope at full scale
   p_noramp_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !ramp_en) |-> (env_out == '1));
endmodule

// File: tb/test_scale_ramp_seq.sv
module test_scale_ramp_seq;
   localparam int FULL = 16383;
   localparam int MAXN = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  sync_in = '0;
   logic [1:0]  sync_sel = '0;
   logic [15:0] holdoff = '0;
   logic        ramp_en = 1'b0;
   logic        interp_en = 1'b0;
   logic [5:0]  down_len_m1 = '0;
   logic [5:0]  up_len_m1 = '0;
   logic [4:0]  rest_len = '0;
   logic        tab_wr_en = 1'b0;
   logic [5:0]  tab_wr_addr = '0;
   logic [13:0] tab_wr_data = '0;
   logic [13:0] env_out;
   logic        commit;

   int n_chk = 0;
   int n_bad = 0;
   int tab [64];
   int exp_env [MAXN];
   int exp_com [MAXN];
   string exp_req [MAXN];
   int exp_n;

   always #4 clk = ~clk;

   scale_ramp_seq i_scale_ramp_seq (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_sel(sync_sel),
      .holdoff(holdoff), .ramp_en(ramp_en), .interp_en(interp_en),
      .down_len_m1(down_len_m1), .up_len_m1(up_len_m1), .rest_len(rest_len),
      .tab_wr_en(tab_wr_en), .tab_wr_addr(tab_wr_addr), .tab_wr_data(tab_wr_data),
      .env_out(env_out), .commit(commit)
   );

   function automatic int mid(int a, int b);
      return (a + b) / 2;
   endfunction

   task automatic push(int e, int c, string r);
      exp_env[exp_n] = e;
      exp_com[exp_n] = c;
      exp_req[exp_n] = r;
      exp_n++;
   endtask

   task automatic check(string req, int act_e, int act_c, int e, int c);
      n_chk++;
      if (act_e != e || act_c != c) begin
         n_bad++;
         $display("FAIL %s: env=%0d commit=%0d expected env=%0d commit=%0d",
                  req, act_e, act_c, e, c);
      end
   endtask

   task automatic build(int h, bit rmp, bit itp, int dl, int ul, int q);
      exp_n = 0;
      for (int i = 0; i <= h; i++) push(FULL, 0, "R3");
      if (!rmp) begin
         push(FULL, 1, "R4");
      end else begin
         for (int p = 0; p <= dl; p++) begin
            int a = dl - p;
            push(tab[a], 0, "R6");
            if (itp) push((p == dl) ? tab[a] : mid(tab[a], tab[a-1]), 0, "R9");
         end
         for (int i = 0; i <= q; i++) push(0, 0, "R8");
         push(0, 1, "R5");
         for (int p = 0; p <= ul; p++) begin
            push(tab[p], 0, "R7");
            if (itp) push((p == ul) ? tab[p] : mid(tab[p], tab[p+1]), 0, "R9");
         end
      end
      push(FULL, 0, "R10");
      push(FULL, 0, "R1");
   endtask

   task automatic wr_tab(int a, int v);
      @(negedge clk);
      tab_wr_en = 1'b1; tab_wr_addr = 6'(a); tab_wr_data = 14'(v);
      @(negedge clk);
      tab_wr_en = 1'b0;
      tab[a] = v;
   endtask

   task automatic run_seq(int sel, int h, bit rmp, bit itp, int dl, int ul, int q,
                          int inject);
      @(negedge clk);
      sync_sel = 2'(sel); holdoff = 16'(h); ramp_en = rmp; interp_en = itp;
      down_len_m1 = 6'(dl); up_len_m1 = 6'(ul); rest_len = 5'(q);
      build(h, rmp, itp, dl, ul, q);
      sync_in = 4'(1 << sel);
      @(negedge clk);
      sync_in = '0;
      for (int i = 0; i < exp_n; i++) begin
         check(exp_req[i], int'(env_out), int'(commit), exp_env[i], exp_com[i]);
         if (inject >= 0 && i == inject) sync_in = 4'(1 << sel);   // R11
         else sync_in = '0;
         @(negedge clk);
      end
      sync_in = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: env=%0d commit=%0d expected sequence end", env_out, commit);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1207));
      for (int i = 0; i < 64; i++) tab[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", int'(env_out), int'(commit), FULL, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(env_out), int'(commit), FULL, 0);

      // R12: ascending table with random steps
      begin
         int lvl = 0;
         for (int i = 0; i < 64; i++) begin
            lvl = lvl + 1 + int'($urandom_range(0, 250));
            if (lvl > FULL) lvl = FULL;
            wr_tab(i, lvl);
         end
      end

      // R2: unselected line does nothing
      @(negedge clk);
      sync_sel = 2'd1; sync_in = 4'b1101;
      @(negedge clk);
      sync_in = '0;
      for (int i = 0; i < 6; i++) begin
         check("R2", int'(env_out), int'(commit), FULL, 0);
         @(negedge clk);
      end

      // directed corners
      run_seq(0, 0, 1'b0, 1'b0, 0, 0, 0, -1);       // R4 minimal
      run_seq(1, 5, 1'b0, 1'b0, 0, 0, 0, 2);        // R11 during hold-off
      run_seq(2, 0, 1'b1, 1'b0, 0, 0, 0, -1);       // R6 R7 length one
      run_seq(3, 2, 1'b1, 1'b0, 3, 3, 0, 8);        // R5 R8
      run_seq(0, 1, 1'b1, 1'b1, 0, 0, 3, -1);       // R9 single step
      run_seq(1, 0, 1'b1, 1'b1, 63, 63, 31, 100);   // R9 full length
      run_seq(2, 1500, 1'b0, 1'b0, 0, 0, 0, 700);   // R3 long hold-off

      // R12: overwrite entry 0 and observe it on a one-step fade
      wr_tab(0, 12345);
      run_seq(3, 0, 1'b1, 1'b0, 0, 0, 1, -1);

      // random mix
      for (int k = 0; k < 24; k++) begin
         int sel = int'($urandom_range(0, 3));
         int h   = int'($urandom_range(0, 40));
         bit rmp = 1'($urandom_range(0, 1));
         bit itp = 1'($urandom_range(0, 1));
         int dl  = int'($urandom_range(0, 63));
         int ul  = int'($urandom_range(0, 63));
         int q   = int'($urandom_range(0, 31));
         int inj = int'($urandom_range(0, 1)) ? int'($urandom_range(0, 60)) : -1;
         if (k % 6 == 0) wr_tab(int'($urandom_range(0, 63)), int'($urandom_range(0, FULL)));
         run_seq(sel, h, rmp, itp, dl, ul, q, inj);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule